// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a clock generator and the output pins of a clock synthesizer. It receives an internal CPU clock and an internal PCI clock and drives a group of gated copies: a CPU pair, five PCI outputs and one free-running PCI output. Two active-low stop requests let external power-management logic park the CPU pair or the five PCI outputs. A per-output enable word, held by a configuration register elsewhere, switches single outputs off. An asynchronous power-down input forces every output low.

Both stop requests are sampled on the rising edge of the internal PCI clock, which is the clock behind the free-running output. The CPU request then crosses into the CPU clock domain through a short resynchronizer. Each output has a gate flop clocked on the falling edge of its own source clock, ANDed with that clock. An output therefore only changes while its source clock is low. It stops low and restarts with a complete high phase. The free-running PCI output answers only to its enable and to power-down.

Top module: `ckg_stop_gate`

## Requirements
- R1: When `cpu_stop_n` is sampled low at a rising edge of `clk_pci`, each enabled CPU output makes exactly two more rising edges after that edge, both outputs together, and then stays low.
- R2: When `cpu_stop_n` is sampled high again at a rising edge of `clk_pci`, the first rising edge on each enabled CPU output is the third rising edge of `clk_cpu` after that `clk_pci` edge.
- R3: When `pci_stop_n` is sampled low at a rising edge of `clk_pci`, the five PCI outputs give their last rising edge at that same edge and stay low from then on. The CPU outputs are not affected.
- R4: When `pci_stop_n` is sampled high again at a rising edge of `clk_pci`, the PCI outputs resume one `clk_pci` period later.
- R5: `pcif_clk_out` follows `clk_pci` whenever `pcif_en` is 1 and power-down is not active, whatever the two stop inputs do.
- R6: Every high pulse on any output lasts a full high phase of its source clock, even when a stop, an enable or power-down changes while that clock is high.
- R7: Output i is held low while its enable bit (`cpu_en[i]`, `pci_en[i]`, `pcif_en`; 1 = enabled) is 0, starting from the next falling edge of its source clock. Other outputs keep running.
- R8: `pwr_dn_n` low passes through a two-stage `clk_pci` synchronizer and then holds every output low, including `pcif_clk_out`, with the stop inputs ignored. After release, all outputs resume.
- R9: While `rst_n` is low, every output is low. After release, the outputs start with full pulses once the synchronizers have filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Internal PCI clock, also the sampling clock for the requests |
| clk_cpu | input | 1 | Internal CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low CPU pair stop request, synchronous to clk_pci |
| pci_stop_n | input | 1 | Active-low PCI group stop request, synchronous to clk_pci |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down |
| cpu_en | input | CPU_OUTS | Per-output enable for the CPU pair, 1 = enabled |
| pci_en | input | PCI_OUTS | Per-output enable for the PCI group, 1 = enabled |
| pcif_en | input | 1 | Enable for the free-running PCI output |
| cpu_clk_out | output | CPU_OUTS | Gated CPU clocks |
| pci_clk_out | output | PCI_OUTS | Gated PCI clocks |
| pcif_clk_out | output | 1 | Free-running PCI clock |

## Verification
On every falling edge of the source clocks, the assertions check that a disabled output stayed low during the high phase just ended, and that a sampled PCI stop or power-down held the affected outputs low with the right delay. They also check that the free-running output kept running whenever it was enabled and power was up, and that the two CPU outputs agree. The exact latency of the CPU resynchronizer, the edge counts at stop and restart, and the absence of short pulses when controls change in mid-phase can only be seen in the bench scenarios. There, edge counters and a pulse-width monitor observe the outputs over fixed windows.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;

    // Group run requests captured in the PCI clock domain
    typedef struct packed {
        logic cpu_run;
        logic pci_run;
    } req_state_t;

    localparam req_state_t REQ_RESET = '{cpu_run: 1'b0, pci_run: 1'b0};

endpackage

// File: rtl/ckg_req_sync.sv
`timescale 1ns/1ps
// Samples the stop requests on the PCI clock and synchronizes power-down.
module ckg_req_sync
    import ckg_pkg::*;
#(
    parameter int PD_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    input  logic pwr_dn_n,
    output logic cpu_run,
    output logic pci_run,
    output logic pd_ok
);

    localparam int PD_MSB = PD_STAGES - 1;

    logic [PD_MSB:0] pd_d, pd_q;
    req_state_t      st_d, st_q;

    always_comb begin
        pd_d[0] = pwr_dn_n;
        for (int i = 1; i < PD_STAGES; i++) begin
            pd_d[i] = pd_q[i-1];
        end
        st_d.cpu_run = cpu_stop_n & pd_q[PD_MSB];
        st_d.pci_run = pci_stop_n & pd_q[PD_MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= '0;
            st_q <= REQ_RESET;
        end else begin
            pd_q <= pd_d;
            st_q <= st_d;
        end
    end

    assign cpu_run = st_q.cpu_run;
    assign pci_run = st_q.pci_run;
    assign pd_ok   = pd_q[PD_MSB];

endmodule

// File: rtl/ckg_gate_bank.sv
`timescale 1ns/1ps
// One group of gated outputs sharing a source clock. An optional
// resynchronizer brings the run request into the source domain; the gate
// flops load on the falling edge so outputs only change while the clock is low.
module ckg_gate_bank #(
    parameter int WIDTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] clk_out
);

    logic             run_s;
    logic [WIDTH-1:0] gate_d, gate_q;

    generate
        if (SYNC_STAGES > 0) begin : g_resync
            logic [SYNC_STAGES-1:0] sync_d, sync_q;

            always_comb begin
                sync_d[0] = run_req;
                for (int i = 1; i < SYNC_STAGES; i++) begin
                    sync_d[i] = sync_q[i-1];
                end
            end

            always_ff @(posedge clk_src or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= sync_d;
                end
            end

            assign run_s = sync_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign run_s = run_req;
        end
    endgenerate

    always_comb begin
        gate_d = en & {WIDTH{run_s}};
    end

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign clk_out = gate_q & {WIDTH{clk_src}};

endmodule

// File: rtl/ckg_stop_gate.sv
`timescale 1ns/1ps
module ckg_stop_gate
    import ckg_pkg::*;
#(
    parameter int CPU_OUTS        = 2,
    parameter int PCI_OUTS        = 5,
    parameter int CPU_SYNC_STAGES = 2,
    parameter int PD_SYNC_STAGES  = 2
) (
    input  logic                clk_pci,
    input  logic                clk_cpu,
    input  logic                rst_n,
    input  logic                cpu_stop_n,
    input  logic                pci_stop_n,
    input  logic                pwr_dn_n,
    input  logic [CPU_OUTS-1:0] cpu_en,
    input  logic [PCI_OUTS-1:0] pci_en,
    input  logic                pcif_en,
    output logic [CPU_OUTS-1:0] cpu_clk_out,
    output logic [PCI_OUTS-1:0] pci_clk_out,
    output logic                pcif_clk_out
);

    logic       cpu_run;
    logic       pci_run;
    logic       pd_ok;
    logic [0:0] pcif_vec;

    ckg_req_sync #(
        .PD_STAGES (PD_SYNC_STAGES)
    ) u_req (
        .clk        (clk_pci),
        .rst_n      (rst_n),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .pwr_dn_n   (pwr_dn_n),
        .cpu_run    (cpu_run),
        .pci_run    (pci_run),
        .pd_ok      (pd_ok)
    );

    // CPU pair: request crosses from the PCI domain
    ckg_gate_bank #(
        .WIDTH       (CPU_OUTS),
        .SYNC_STAGES (CPU_SYNC_STAGES)
    ) u_cpu_bank (
        .clk_src (clk_cpu),
        .rst_n   (rst_n),
        .run_req (cpu_run),
        .en      (cpu_en),
        .clk_out (cpu_clk_out)
    );

    // PCI group: request already in this domain
    ckg_gate_bank #(
        .WIDTH       (PCI_OUTS),
        .SYNC_STAGES (0)
    ) u_pci_bank (
        .clk_src (clk_pci),
        .rst_n   (rst_n),
        .run_req (pci_run),
        .en      (pci_en),
        .clk_out (pci_clk_out)
    );

    // Free-running output: only power-down and its own enable apply
    ckg_gate_bank #(
        .WIDTH       (1),
        .SYNC_STAGES (0)
    ) u_pcif_bank (
        .clk_src (clk_pci),
        .rst_n   (rst_n),
        .run_req (pd_ok),
        .en      (pcif_en),
        .clk_out (pcif_vec)
    );

    assign pcif_clk_out = pcif_vec[0];

endmodule

// File: rtl/ckg_stop_gate_chk.sv
`timescale 1ns/1ps
module ckg_stop_gate_chk #(
    parameter int CPU_OUTS = 2,
    parameter int PCI_OUTS = 5
) (
    input logic                clk_pci,
    input logic                clk_cpu,
    input logic                rst_n,
    input logic                pci_stop_n,
    input logic [CPU_OUTS-1:0] cpu_en,
    input logic [PCI_OUTS-1:0] pci_en,
    input logic                pcif_en,
    input logic                pd_ok,
    input logic [CPU_OUTS-1:0] cpu_clk_out,
    input logic [PCI_OUTS-1:0] pci_clk_out,
    input logic                pcif_clk_out
);

    // Checker-side capture of the PCI stop request at the sampling edge
    logic stop_seen_q;
    always_ff @(posedge clk_pci or negedge rst_n) begin
        if (!rst_n) begin
            stop_seen_q <= 1'b0;
        end else begin
            stop_seen_q <= pci_stop_n;
        end
    end

    // At a falling edge, the sampled output value is the high phase just ended.
    p_pci_stop_low_r3: assert property (@(negedge clk_pci) disable iff (!rst_n)
        !$past(stop_seen_q) |-> (pci_clk_out == '0));

    p_pcif_free_r5: assert property (@(negedge clk_pci) disable iff (!rst_n)
        ($past(pd_ok) && $past(pcif_en)) |-> pcif_clk_out);

    p_pd_pcif_r8: assert property (@(negedge clk_pci) disable iff (!rst_n)
        !$past(pd_ok) |-> !pcif_clk_out);

    p_pd_pci_r8: assert property (@(negedge clk_pci) disable iff (!rst_n)
        !$past(pd_ok, 2) |-> (pci_clk_out == '0));

    p_cpu_pair_r1: assert property (@(negedge clk_cpu) disable iff (!rst_n)
        (&$past(cpu_en)) |-> ((cpu_clk_out == '0) || (&cpu_clk_out)));

    for (genvar g = 0; g < PCI_OUTS; g++) begin : g_pci_en
        p_pci_en_r7: assert property (@(negedge clk_pci) disable iff (!rst_n)
            !$past(pci_en[g]) |-> !pci_clk_out[g]);
    end

    for (genvar g = 0; g < CPU_OUTS; g++) begin : g_cpu_en
        p_cpu_en_r7: assert property (@(negedge clk_cpu) disable iff (!rst_n)
            !$past(cpu_en[g]) |-> !cpu_clk_out[g]);
    end

endmodule

bind ckg_stop_gate ckg_stop_gate_chk #(
    .CPU_OUTS (CPU_OUTS),
    .PCI_OUTS (PCI_OUTS)
) u_chk (
    .clk_pci      (clk_pci),
    .clk_cpu      (clk_cpu),
    .rst_n        (rst_n),
    .pci_stop_n   (pci_stop_n),
    .cpu_en       (cpu_en),
    .pci_en       (pci_en),
    .pcif_en      (pcif_en),
    .pd_ok        (pd_ok),
    .cpu_clk_out  (cpu_clk_out),
    .pci_clk_out  (pci_clk_out),
    .pcif_clk_out (pcif_clk_out)
);

// File: tb/ckg_stop_gate_test.sv
`timescale 1ns/1ps
module ckg_stop_gate_test;

    logic       clk;
    logic       clk_cpu;
    logic       rst_n;
    logic       cpu_stop_n;
    logic       pci_stop_n;
    logic       pwr_dn_n;
    logic [1:0] cpu_en;
    logic [4:0] pci_en;
    logic       pcif_en;
    logic [1:0] cpu_clk_out;
    logic [4:0] pci_clk_out;
    logic       pcif_clk_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ckg_stop_gate uut (
        .clk_pci      (clk),
        .clk_cpu      (clk_cpu),
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .pwr_dn_n     (pwr_dn_n),
        .cpu_en       (cpu_en),
        .pci_en       (pci_en),
        .pcif_en      (pcif_en),
        .cpu_clk_out  (cpu_clk_out),
        .pci_clk_out  (pci_clk_out),
        .pcif_clk_out (pcif_clk_out)
    );

    // 50 MHz PCI clock (rises at 10 + 20k); CPU clock at twice the rate,
    // rising 7 ns and 17 ns after each PCI rising edge.
    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    initial begin
        clk_cpu = 1'b0;
        #7;
        forever begin
            clk_cpu = 1'b1;
            #5;
            clk_cpu = 1'b0;
            #5;
        end
    end

    // Output monitor: samples between edges, counts rising edges, flags short pulses
    int cpu_cnt [2];
    int pci_cnt [5];
    int pcif_cnt;
    int runt_cnt;
    int cpu_hi  [2];
    int pci_hi  [5];
    int pcif_hi;
    logic [1:0] cpu_prev;
    logic [4:0] pci_prev;
    logic       pcif_prev;

    initial begin
        for (int i = 0; i < 2; i++) begin cpu_cnt[i] = 0; cpu_hi[i] = 0; end
        for (int i = 0; i < 5; i++) begin pci_cnt[i] = 0; pci_hi[i] = 0; end
        pcif_cnt = 0; pcif_hi = 0; runt_cnt = 0;
        cpu_prev = '0; pci_prev = '0; pcif_prev = 1'b0;
        #0.5;
        forever begin
            for (int i = 0; i < 2; i++) begin
                if (cpu_clk_out[i] && !cpu_prev[i]) begin cpu_cnt[i]++; cpu_hi[i] = 0; end
                if (cpu_clk_out[i]) cpu_hi[i]++;
                if (!cpu_clk_out[i] && cpu_prev[i] && cpu_hi[i] < 5) runt_cnt++;
            end
            for (int i = 0; i < 5; i++) begin
                if (pci_clk_out[i] && !pci_prev[i]) begin pci_cnt[i]++; pci_hi[i] = 0; end
                if (pci_clk_out[i]) pci_hi[i]++;
                if (!pci_clk_out[i] && pci_prev[i] && pci_hi[i] < 10) runt_cnt++;
            end
            if (pcif_clk_out && !pcif_prev) begin pcif_cnt++; pcif_hi = 0; end
            if (pcif_clk_out) pcif_hi++;
            if (!pcif_clk_out && pcif_prev && pcif_hi < 10) runt_cnt++;
            cpu_prev  = cpu_clk_out;
            pci_prev  = pci_clk_out;
            pcif_prev = pcif_clk_out;
            #1;
        end
    end

    int dcpu [2];
    int dpci [5];
    int dpcif;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Advance n PCI periods, landing 5 ns after a falling edge (5 ns before a rising edge)
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #5;
    endtask

    // Count rising edges on every output over n PCI periods
    task automatic measure(input int n);
        int b_cpu [2];
        int b_pci [5];
        int b_pcif;
        for (int i = 0; i < 2; i++) b_cpu[i] = cpu_cnt[i];
        for (int i = 0; i < 5; i++) b_pci[i] = pci_cnt[i];
        b_pcif = pcif_cnt;
        step(n);
        for (int i = 0; i < 2; i++) dcpu[i] = cpu_cnt[i] - b_cpu[i];
        for (int i = 0; i < 5; i++) dpci[i] = pci_cnt[i] - b_pci[i];
        dpcif = pcif_cnt - b_pcif;
    endtask

    task automatic chk_cpu(input string tag, input int exp);
        for (int i = 0; i < 2; i++) chk(tag, dcpu[i], exp);
    endtask

    task automatic chk_pci(input string tag, input int exp);
        for (int i = 0; i < 5; i++) chk(tag, dpci[i], exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dn_n = 1'b1;
        cpu_en = '1; pci_en = '1; pcif_en = 1'b1;
        measure(8);
        chk_cpu("R9 cpu during reset", 0);
        chk_pci("R9 pci during reset", 0);
        chk("R9 pcif during reset", dpcif, 0);
        rst_n = 1'b1;
        step(6);
        measure(6);
        chk_cpu("R9 cpu after reset", 12);
        chk_pci("R9 pci after reset", 6);
        chk("R9 pcif after reset", dpcif, 6);
        chk("R9 no short pulse at start", runt_cnt, 0);
    endtask

    task automatic t_pci_stop;
        pci_stop_n = 1'b0;
        measure(6);
        chk_pci("R3 pci last edge", 1);
        chk_cpu("R3 cpu untouched", 12);
        chk("R5 pcif during pci stop", dpcif, 6);
        measure(6);
        chk_pci("R3 pci held low", 0);
        pci_stop_n = 1'b1;
        measure(6);
        chk_pci("R4 pci restart latency", 5);
        measure(6);
        chk_pci("R4 pci running", 6);
    endtask

    task automatic t_cpu_stop;
        cpu_stop_n = 1'b0;
        measure(6);
        chk_cpu("R1 cpu two edges after sample", 3);
        chk_pci("R1 pci untouched", 6);
        chk("R5 pcif during cpu stop", dpcif, 6);
        measure(6);
        chk_cpu("R1 cpu held low", 0);
        cpu_stop_n = 1'b1;
        measure(6);
        chk_cpu("R2 cpu restart latency", 9);
        measure(6);
        chk_cpu("R2 cpu running", 12);
    endtask

    task automatic t_both_stop;
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        step(6);
        measure(6);
        chk("R5 pcif with both stopped", dpcif, 6);
        chk_cpu("R1 cpu stopped", 0);
        chk_pci("R3 pci stopped", 0);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        step(6);
    endtask

    task automatic t_enables;
        cpu_en = 2'b01; pci_en = 5'b11011;
        step(2);
        measure(6);
        chk("R7 cpu1 disabled", dcpu[1], 0);
        chk("R7 cpu0 enabled", dcpu[0], 12);
        chk("R7 pci2 disabled", dpci[2], 0);
        chk("R7 pci0 enabled", dpci[0], 6);
        chk("R7 pci4 enabled", dpci[4], 6);
        pcif_en = 1'b0;
        step(2);
        measure(6);
        chk("R7 pcif disabled", dpcif, 0);
        chk("R7 pci1 unaffected", dpci[1], 6);
        cpu_en = '1; pci_en = '1; pcif_en = 1'b1;
        step(2);
        measure(6);
        chk_cpu("R7 cpu re-enabled", 12);
        chk_pci("R7 pci re-enabled", 6);
        chk("R7 pcif re-enabled", dpcif, 6);
    endtask

    // Controls change while the source clocks are high
    task automatic t_runt;
        int base;
        base = runt_cnt;
        #14 cpu_en = 2'b10;
        #20 cpu_en = 2'b11; pci_stop_n = 1'b0; pci_en = 5'b01111;
        #20 pci_stop_n = 1'b1; cpu_stop_n = 1'b0; pci_en = 5'b11111;
        #20 cpu_stop_n = 1'b1; pcif_en = 1'b0;
        #20 pcif_en = 1'b1;
        @(negedge clk);
        #5;
        step(8);
        chk("R6 no short pulse on mid-phase changes", runt_cnt - base, 0);
        measure(4);
        chk_cpu("R6 cpu running after changes", 8);
        chk_pci("R6 pci running after changes", 4);
    endtask

    task automatic t_power_down;
        pwr_dn_n = 1'b0;
        step(4);
        measure(6);
        chk_cpu("R8 cpu held in power-down", 0);
        chk_pci("R8 pci held in power-down", 0);
        chk("R8 pcif held in power-down", dpcif, 0);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0;
        measure(4);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        measure(4);
        chk_cpu("R8 stop inputs ignored cpu", 0);
        chk_pci("R8 stop inputs ignored pci", 0);
        chk("R8 stop inputs ignored pcif", dpcif, 0);
        pwr_dn_n = 1'b1;
        step(6);
        measure(6);
        chk_cpu("R8 cpu after release", 12);
        chk_pci("R8 pci after release", 6);
        chk("R8 pcif after release", dpcif, 6);
        chk("R6 no short pulse overall", runt_cnt, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dn_n = 1'b1;
        cpu_en = '1; pci_en = '1; pcif_en = 1'b1;
        #5;
        t_reset();
        t_pci_stop();
        t_cpu_stop();
        t_both_stop();
        t_enables();
        t_runt();
        t_power_down();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule